// File: doc/BRIEF.md
# IR Burst Timer

This block is a 16-bit up-counter with five capture/compare channels and a companion 8-bit carrier timer. Each counter has its own prescaler. The main counter runs from zero up to a programmed period value and then wraps back to zero. Each channel either drives a PWM level from a compare value or, in capture mode, stores the count when a selected edge appears on its input. Capture inputs first pass through a two-stage synchroniser.

The carrier timer produces a square-ish PWM carrier from its own period and compare values. In IR mode the main counter stops using its prescaled clock. It then steps once for every completed carrier period. The IR output is channel 0's PWM level gated by the carrier, so a burst of carrier pulses is emitted while channel 0 is high. Once software has set up the registers, it can form consumer-IR envelopes without further help.

All configuration goes through a simple single-cycle register write port. The counters, flags and capture results appear directly on output ports.

Top module: `ir_burst_timer`

## Requirements
- R1: Each prescaler has a 2-bit divide select: 0 divides by 1, 1 by 8, 2 by 32, 3 by 128. While the main timer is running outside IR mode, the count advances once per divisor cycles. While it is stopped, the count holds and its prescaler restarts from zero.
- R2: The main count advances from 0 up to the period value and returns to 0 on the next advance. If the count is already at or above a newly written period, the next advance also returns it to 0.
- R3: Each wrap of the main count sets the overflow flag. The flag stays set until a write to address 5 with data bit 5 set. A wrap in the same cycle as the clear leaves the flag set.
- R4: A channel in compare mode outputs 1 while the count is below its compare value and 0 otherwise. A compare value of 0 keeps the output low.
- R5: A channel in capture mode holds its PWM output at 0.
- R6: Capture inputs pass through two synchroniser flops. The edge select encoding is 0 for none, 1 for rising, 2 for falling and 3 for both. A selected edge stores the count into the channel's capture value and sets its capture flag. The result appears on the third rising clock after the input changes.
- R7: A capture input pulse that lasts a single clock period is still recognised. Capture flags stay set until a write to address 5 with the channel's data bit set (bit i for channel i). A new capture in the same cycle as the clear keeps the flag set.
- R8: The carrier counter runs from 0 to its 8-bit period through its own prescaler. Its output is 1 while the carrier timer is enabled and its count is below the carrier compare value.
- R9: In IR mode the main count advances exactly once per carrier-counter wrap, and the main prescaler has no effect on it.
- R10: In IR mode the IR output equals channel 0's PWM output AND the carrier output. Outside IR mode it is 0.
- R11: After reset all counts, flags, capture values and configuration are 0, so every output is 0.
- R12: Register writes take effect on the next clock.
  - Address 0: bit 0 main run, bits 2:1 main divide select, bit 3 IR mode.
  - Address 1: main period.
  - Address 2: bit 0 carrier run, bits 2:1 carrier divide select.
  - Address 3: carrier period (bits 7:0).
  - Address 4: carrier compare (bits 7:0).
  - Address 5: flag clear.
  - Address 8+i: channel i compare value.
  - Address 16+i: channel i setup, with bit 0 selecting capture mode and bits 2:1 the edge select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register write address |
| wrData | input | 16 | Register write data |
| capIn | input | 5 | Asynchronous capture inputs, one per channel |
| count | output | 16 | Main counter value |
| ovfFlag | output | 1 | Sticky main-counter wrap flag |
| pwmOut | output | 5 | Per-channel PWM levels |
| capFlags | output | 5 | Sticky per-channel capture flags |
| capValues | output | 80 | Captured counts, channel i at bits 16*i+15:16*i |
| carrierOut | output | 1 | Carrier PWM level |
| irOut | output | 1 | Carrier-gated channel 0 level in IR mode |

## Verification
The hardest situation to reach is a flag clear landing in the same cycle as a new capture or wrap. Another is a period written below the running count, which matters most under the slow divide settings. The stimulus deliberately rewrites the period while the count is high. It also issues flag clears while capture inputs toggle with pulses of one to three clocks, so the races occur naturally. IR mode is tested with two carrier divide settings, with channel 0 crossing its compare value during a carrier burst. A behavioural model covers the whole sequence and is compared against the design on every clock.

// File: rtl/irt_pkg.sv
package irt_pkg;

  // Edge selection for capture channels
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edgeSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic mainPreTick;
    logic carPreTick;
    logic ovfClr;
  } timerStrobe_t;

  // Register address map
  localparam int ADR_MAIN_CTL = 0;
  localparam int ADR_PERIOD   = 1;
  localparam int ADR_CAR_CTL  = 2;
  localparam int ADR_CAR_PER  = 3;
  localparam int ADR_CAR_CMP  = 4;
  localparam int ADR_FLAG_CLR = 5;
  localparam int ADR_CMP_BASE = 8;
  localparam int ADR_CFG_BASE = 16;

endpackage

// File: rtl/irt_prescale.sv
module irt_prescale #(
  parameter int PRE_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] lastVal;

  always_comb begin
    case (sel)
      2'd0:    lastVal = PRE_W'(0);
      2'd1:    lastVal = PRE_W'(7);
      2'd2:    lastVal = PRE_W'(31);
      default: lastVal = PRE_W'(127);
    endcase
  end

  assign tick = run && (preCnt == lastVal);

  always_ff @(posedge clk) begin
    if (!rst_n)           preCnt <= '0;
    else if (!run || tick) preCnt <= '0;
    else                  preCnt <= preCnt + 1'b1;
  end
endmodule

// File: rtl/irt_ctrl.sv
module irt_ctrl
  import irt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CAR_W  = 8,
  parameter int NUM_CH = 5,
  parameter int ADDR_W = 5,
  parameter int PRE_W  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [CNT_W-1:0]         wrData,
  output timerStrobe_t             strb,
  output logic                     runMain,
  output logic                     irMode,
  output logic [CNT_W-1:0]         mainPeriod,
  output logic                     carRun,
  output logic [CAR_W-1:0]         carPeriod,
  output logic [CAR_W-1:0]         carCompare,
  output logic [NUM_CH*CNT_W-1:0]  chCompare,
  output logic [NUM_CH-1:0]        chCapMode,
  output logic [2*NUM_CH-1:0]      chEdge,
  output logic [NUM_CH-1:0]        capClr
);
  logic [1:0] mainSel, carSel;
  logic       flagWr;

  assign flagWr = wrEn && (wrAddr == ADDR_W'(ADR_FLAG_CLR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      runMain    <= 1'b0;
      mainSel    <= 2'd0;
      irMode     <= 1'b0;
      mainPeriod <= '0;
      carRun     <= 1'b0;
      carSel     <= 2'd0;
      carPeriod  <= '0;
      carCompare <= '0;
    end else if (wrEn) begin
      case (int'(wrAddr))
        ADR_MAIN_CTL: begin
          runMain <= wrData[0];
          mainSel <= wrData[2:1];
          irMode  <= wrData[3];
        end
        ADR_PERIOD:  mainPeriod <= wrData;
        ADR_CAR_CTL: begin
          carRun <= wrData[0];
          carSel <= wrData[2:1];
        end
        ADR_CAR_PER: carPeriod  <= wrData[CAR_W-1:0];
        ADR_CAR_CMP: carCompare <= wrData[CAR_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chReg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chCompare[i*CNT_W +: CNT_W] <= '0;
        chCapMode[i]                <= 1'b0;
        chEdge[2*i +: 2]            <= EDGE_NONE;
      end else if (wrEn) begin
        if (wrAddr == ADDR_W'(ADR_CMP_BASE + i))
          chCompare[i*CNT_W +: CNT_W] <= wrData;
        if (wrAddr == ADDR_W'(ADR_CFG_BASE + i)) begin
          chCapMode[i]     <= wrData[0];
          chEdge[2*i +: 2] <= wrData[2:1];
        end
      end
    end
    assign capClr[i] = flagWr && wrData[i];
  end

  assign strb.ovfClr = flagWr && wrData[NUM_CH];

  irt_prescale #(.PRE_W(PRE_W)) mainPre_i (
    .clk(clk), .rst_n(rst_n), .run(runMain), .sel(mainSel), .tick(strb.mainPreTick)
  );

  irt_prescale #(.PRE_W(PRE_W)) carPre_i (
    .clk(clk), .rst_n(rst_n), .run(carRun), .sel(carSel), .tick(strb.carPreTick)
  );
endmodule

// File: rtl/irt_datapath.sv
module irt_datapath
  import irt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CAR_W  = 8,
  parameter int NUM_CH = 5,
  parameter int SYNC_N = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  timerStrobe_t             strb,
  input  logic                     runMain,
  input  logic                     irMode,
  input  logic [CNT_W-1:0]         mainPeriod,
  input  logic                     carRun,
  input  logic [CAR_W-1:0]         carPeriod,
  input  logic [CAR_W-1:0]         carCompare,
  input  logic [NUM_CH*CNT_W-1:0]  chCompare,
  input  logic [NUM_CH-1:0]        chCapMode,
  input  logic [2*NUM_CH-1:0]      chEdge,
  input  logic [NUM_CH-1:0]        capClr,
  input  logic [NUM_CH-1:0]        capIn,
  output logic [CNT_W-1:0]         count,
  output logic                     ovfFlag,
  output logic [NUM_CH-1:0]        pwmOut,
  output logic [NUM_CH-1:0]        capFlags,
  output logic [NUM_CH*CNT_W-1:0]  capValues,
  output logic                     carrierOut,
  output logic                     irOut
);
  logic [CAR_W-1:0] carCnt;
  logic             carWrap, mainTick, mainWrap;

  // Carrier timer
  assign carWrap = strb.carPreTick && (carCnt >= carPeriod);

  always_ff @(posedge clk) begin
    if (!rst_n)               carCnt <= '0;
    else if (strb.carPreTick) carCnt <= carWrap ? '0 : carCnt + 1'b1;
  end

  assign carrierOut = carRun && (carCnt < carCompare);

  // Main timer: tick source chosen by IR mode
  assign mainTick = runMain && (irMode ? carWrap : strb.mainPreTick);
  assign mainWrap = mainTick && (count >= mainPeriod);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (mainTick) count <= mainWrap ? '0 : count + 1'b1;
      if (mainWrap)         ovfFlag <= 1'b1;
      else if (strb.ovfClr) ovfFlag <= 1'b0;
    end
  end

  // Channels
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [SYNC_N-1:0] syncQ;
    logic              prevQ, risen, fallen, hit;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        syncQ <= '0;
        prevQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_N-2:0], capIn[i]};
        prevQ <= syncQ[SYNC_N-1];
      end
    end

    assign risen  = syncQ[SYNC_N-1] && !prevQ;
    assign fallen = !syncQ[SYNC_N-1] && prevQ;
    assign hit    = chCapMode[i] && ((chEdge[2*i] && risen) || (chEdge[2*i+1] && fallen));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        capValues[i*CNT_W +: CNT_W] <= '0;
        capFlags[i]                 <= 1'b0;
      end else if (hit) begin
        capValues[i*CNT_W +: CNT_W] <= count;
        capFlags[i]                 <= 1'b1;
      end else if (capClr[i]) begin
        capFlags[i] <= 1'b0;
      end
    end

    assign pwmOut[i] = !chCapMode[i] && (count < chCompare[i*CNT_W +: CNT_W]);
  end

  assign irOut = irMode && pwmOut[0] && carrierOut;
endmodule

// File: rtl/ir_burst_timer.sv
module ir_burst_timer
  import irt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CAR_W  = 8,
  parameter int NUM_CH = 5,
  parameter int ADDR_W = 5,
  parameter int PRE_W  = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [CNT_W-1:0]        wrData,
  input  logic [NUM_CH-1:0]       capIn,
  output logic [CNT_W-1:0]        count,
  output logic                    ovfFlag,
  output logic [NUM_CH-1:0]       pwmOut,
  output logic [NUM_CH-1:0]       capFlags,
  output logic [NUM_CH*CNT_W-1:0] capValues,
  output logic                    carrierOut,
  output logic                    irOut
);
  timerStrobe_t            strb;
  logic                    runMain, irMode, carRun;
  logic [CNT_W-1:0]        mainPeriod;
  logic [CAR_W-1:0]        carPeriod, carCompare;
  logic [NUM_CH*CNT_W-1:0] chCompare;
  logic [NUM_CH-1:0]       chCapMode, capClr;
  logic [2*NUM_CH-1:0]     chEdge;

  irt_ctrl #(
    .CNT_W(CNT_W), .CAR_W(CAR_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .PRE_W(PRE_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .runMain(runMain), .irMode(irMode), .mainPeriod(mainPeriod),
    .carRun(carRun), .carPeriod(carPeriod), .carCompare(carCompare),
    .chCompare(chCompare), .chCapMode(chCapMode), .chEdge(chEdge), .capClr(capClr)
  );

  irt_datapath #(
    .CNT_W(CNT_W), .CAR_W(CAR_W), .NUM_CH(NUM_CH), .SYNC_N(2)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .runMain(runMain), .irMode(irMode),
    .mainPeriod(mainPeriod), .carRun(carRun), .carPeriod(carPeriod),
    .carCompare(carCompare), .chCompare(chCompare), .chCapMode(chCapMode),
    .chEdge(chEdge), .capClr(capClr), .capIn(capIn), .count(count),
    .ovfFlag(ovfFlag), .pwmOut(pwmOut), .capFlags(capFlags),
    .capValues(capValues), .carrierOut(carrierOut), .irOut(irOut)
  );
endmodule

// File: rtl/ir_burst_timer_chk.sv
module ir_burst_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flagWr,
  input logic              ovfClrBit,
  input logic [CNT_W-1:0]  count,
  input logic              ovfFlag,
  input logic              pwm0,
  input logic [NUM_CH-1:0] capFlags,
  input logic              carrierOut,
  input logic              irOut
);
  // R2: count either holds, steps by one, or returns to zero
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

  // R3: overflow flag is sticky unless cleared
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfFlag && !(flagWr && ovfClrBit)) |=> ovfFlag);

  // R7: capture flags never drop without a write to the flag-clear address
  a_r7_cap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flagWr |=> ((capFlags & $past(capFlags)) == $past(capFlags)));

  // R10: IR output only pulses when both channel 0 and the carrier are high
  a_r10_ir_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irOut |-> (pwm0 && carrierOut));
endmodule

bind ir_burst_timer ir_burst_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .flagWr(wrEn && (wrAddr == ADDR_W'(5))),
  .ovfClrBit(wrData[NUM_CH]),
  .count(count),
  .ovfFlag(ovfFlag),
  .pwm0(pwmOut[0]),
  .capFlags(capFlags),
  .carrierOut(carrierOut),
  .irOut(irOut)
);

// File: tb/ir_burst_timer_tb_top.sv
module ir_burst_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 5;
  localparam int CW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wrEn = 1'b0;
  logic [4:0]      wrAddr = '0;
  logic [CW-1:0]   wrData = '0;
  logic [NCH-1:0]  capIn = '0;
  logic [CW-1:0]   count;
  logic            ovfFlag, carrierOut, irOut;
  logic [NCH-1:0]  pwmOut, capFlags;
  logic [NCH*CW-1:0] capValues;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_burst_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .capIn(capIn), .count(count), .ovfFlag(ovfFlag), .pwmOut(pwmOut),
    .capFlags(capFlags), .capValues(capValues), .carrierOut(carrierOut), .irOut(irOut)
  );

  // ---------------- reference model ----------------
  int mRun, mSel, irm, mPer, cRun, cSel, cPer, cCmp;
  int mPre, cPre, mCnt, cCnt;
  int cmpV[NCH];
  int capMd[NCH];
  int edg[NCH];
  int s1[NCH], s2[NCH], pv[NCH];
  int capV[NCH];
  int capF[NCH];
  int ovf;

  function automatic int divOf(int s);
    return (s == 0) ? 1 : (s == 1) ? 8 : (s == 2) ? 32 : 128;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mRun = 0; mSel = 0; irm = 0; mPer = 0; cRun = 0; cSel = 0; cPer = 0; cCmp = 0;
      mPre = 0; cPre = 0; mCnt = 0; cCnt = 0; ovf = 0;
      for (int i = 0; i < NCH; i++) begin
        cmpV[i] = 0; capMd[i] = 0; edg[i] = 0; s1[i] = 0; s2[i] = 0; pv[i] = 0;
        capV[i] = 0; capF[i] = 0;
      end
    end else begin
      bit pT, cT, cW, mT, mW, clrW;
      pT = (mRun != 0) && (mPre == divOf(mSel) - 1);
      cT = (cRun != 0) && (cPre == divOf(cSel) - 1);
      cW = cT && (cCnt >= cPer);
      mT = (mRun != 0) && ((irm != 0) ? cW : pT);
      mW = mT && (mCnt >= mPer);
      clrW = wrEn && (wrAddr == 5'd5);
      mPre = (mRun == 0 || pT) ? 0 : mPre + 1;
      cPre = (cRun == 0 || cT) ? 0 : cPre + 1;
      if (cT) cCnt = cW ? 0 : cCnt + 1;
      for (int i = 0; i < NCH; i++) begin
        bit rs, fl;
        rs = (s2[i] == 1) && (pv[i] == 0);
        fl = (s2[i] == 0) && (pv[i] == 1);
        if (capMd[i] != 0 && ((edg[i][0] && rs) || (edg[i][1] && fl))) begin
          capV[i] = mCnt; capF[i] = 1;
        end else if (clrW && wrData[i]) capF[i] = 0;
        pv[i] = s2[i]; s2[i] = s1[i]; s1[i] = int'(capIn[i]);
      end
      if (mW) ovf = 1;
      else if (clrW && wrData[5]) ovf = 0;
      if (mT) mCnt = mW ? 0 : mCnt + 1;
      if (wrEn) begin
        case (int'(wrAddr))
          0: begin mRun = int'(wrData[0]); mSel = int'(wrData[2:1]); irm = int'(wrData[3]); end
          1: mPer = int'(wrData);
          2: begin cRun = int'(wrData[0]); cSel = int'(wrData[2:1]); end
          3: cPer = int'(wrData[7:0]);
          4: cCmp = int'(wrData[7:0]);
          default: begin
            for (int i = 0; i < NCH; i++) begin
              if (int'(wrAddr) == 8 + i) cmpV[i] = int'(wrData);
              if (int'(wrAddr) == 16 + i) begin
                capMd[i] = int'(wrData[0]); edg[i] = int'(wrData[2:1]);
              end
            end
          end
        endcase
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmpAll();
    int expPwm0, expCar;
    chk(int'(count) == mCnt, "R2 count", int'(count), mCnt);
    chk(int'(ovfFlag) == ovf, "R3 overflow flag", int'(ovfFlag), ovf);
    for (int i = 0; i < NCH; i++) begin
      int ep;
      ep = (capMd[i] == 0 && mCnt < cmpV[i]) ? 1 : 0;
      chk(int'(pwmOut[i]) == ep, (capMd[i] != 0) ? "R5 pwm in capture mode" : "R4 pwm level",
          int'(pwmOut[i]), ep);
      chk(int'(capFlags[i]) == capF[i], "R7 capture flag", int'(capFlags[i]), capF[i]);
      chk(int'(capValues[i*CW +: CW]) == capV[i], "R6 capture value",
          int'(capValues[i*CW +: CW]), capV[i]);
    end
    expCar  = (cRun != 0 && cCnt < cCmp) ? 1 : 0;
    expPwm0 = (capMd[0] == 0 && mCnt < cmpV[0]) ? 1 : 0;
    chk(int'(carrierOut) == expCar, "R8 carrier", int'(carrierOut), expCar);
    chk(int'(irOut) == ((irm != 0) ? (expPwm0 & expCar) : 0), "R10 ir output",
        int'(irOut), (irm != 0) ? (expPwm0 & expCar) : 0);
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmpAll();
    end
  endtask

  task automatic wr(input int a, input int d);
    wrEn = 1'b1; wrAddr = 5'(a); wrData = CW'(d);
    cyc(1);
    wrEn = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state at the ports
    chk(count == '0 && ovfFlag == 1'b0 && pwmOut == '0 && capFlags == '0 &&
        capValues == '0 && carrierOut == 1'b0 && irOut == 1'b0, "R11 reset state",
        int'(count), 0);
    cyc(2);

    // R12 + R4: compare setup, divide by 1
    wr(8, 4); wr(9, 0); wr(10, 12); wr(11, 7); wr(12, 2);
    wr(1, 9);
    wr(0, 1);
    cyc(1);
    chk(int'(count) == mCnt, "R12 write takes effect next clock", int'(count), mCnt);
    cyc(40);
    // R2: shrink period below running count
    cyc(4);
    wr(1, 3);
    cyc(12);
    chk(int'(count) <= 3, "R2 wrap after smaller period", int'(count), 3);
    // R3: clear overflow, including racing a wrap
    wr(5, 32'h20);
    cyc(3);
    wr(5, 32'h20);
    cyc(5);

    // R1: divide settings
    wr(1, 20); wr(0, 3);   cyc(200);
    chk(int'(count) == mCnt, "R1 divide by 8", int'(count), mCnt);
    wr(0, 5);              cyc(150);
    chk(int'(count) == mCnt, "R1 divide by 32", int'(count), mCnt);
    wr(1, 2); wr(0, 7);    cyc(700);
    chk(int'(count) == mCnt, "R1 divide by 128", int'(count), mCnt);
    // R1: stopped timer holds
    wr(0, 0);
    hold = int'(count);
    cyc(40);
    chk(int'(count) == hold, "R1 stopped count holds", int'(count), hold);

    // R6 / R7: capture channels
    wr(1, 1000); wr(0, 1);
    wr(16 + 1, 1);          // capture, no edge
    wr(16 + 2, 5);          // capture, falling
    wr(16 + 3, 3);          // capture, rising
    wr(16 + 4, 7);          // capture, both
    for (int k = 0; k < 40; k++) begin
      capIn = 5'((k * 13 + 7) ^ (k >> 1));
      cyc((k % 3) + 1);
      if (k % 7 == 3) wr(5, 32'h1f);
    end
    capIn = '0;
    cyc(4);
    // R7: single-clock pulse on rising-edge channel
    wr(5, 32'h1f);
    capIn[3] = 1'b1; cyc(1); capIn[3] = 1'b0;
    cyc(3);
    chk(capFlags[3] == 1'b1, "R7 one-clock pulse captured", int'(capFlags[3]), 1);
    chk(capFlags[1] == 1'b0, "R6 edge select none ignores input", int'(capFlags[1]), 0);
    // R5: capture-mode channel PWM low
    chk(pwmOut[4] == 1'b0, "R5 capture channel output low", int'(pwmOut[4]), 0);

    // R8 / R9 / R10: carrier and IR mode
    wr(16 + 0, 0); wr(8, 2);
    wr(3, 4); wr(4, 2); wr(2, 1);
    cyc(20);
    wr(0, 0);
    wr(1, 5);
    wr(0, 9);               // run + IR mode
    cyc(300);
    chk(int'(count) == mCnt, "R9 count follows carrier wraps", int'(count), mCnt);
    wr(2, 3);               // carrier divide by 8
    cyc(400);
    chk(int'(count) == mCnt, "R9 slow carrier", int'(count), mCnt);
    wr(0, 1);               // IR off
    cyc(30);
    chk(irOut == 1'b0, "R10 ir low outside IR mode", int'(irOut), 0);
    wr(4, 0);
    cyc(10);
    chk(carrierOut == 1'b0, "R8 zero compare keeps carrier low", int'(carrierOut), 0);

    summary();
  end
endmodule